// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block decides which interrupt the processor core services next. It gathers requests from peripheral status flags, each gated by its own enable bit, from a level-sensitive external request line, and from three core-side events: a software-trap strobe, an illegal-opcode strobe and a non-maskable request strobe. It holds one 32-bit pending word with one bit per vector. The core supplies its two mask bits: the general mask and the non-maskable mask. When the core pulses `accept`, the block arbitrates among the pending bits and reports the winning vector. It reports the vector index, the address of the vector's two-byte entry in the vector table, which core mask bit must now be set, and the fixed entry overhead in cycles.

Peripheral bits track their gated flag on every clock, so a source stays pending until software clears the device flag. Bits raised by the three core events are cleared when they are accepted. Several flag/enable pairs can feed one shared vector. The stack push and the vector memory read are done by the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending word is all zero, and `vec_valid`, `vec_idx`, `vec_addr`, `set_i`, `set_x` and `entry_cycles` are all 0. An accept with no request produces no vector.
- R2: Peripheral pair p is active only when `periph_flag[p]` and `periph_en[p]` are both 1. Pairs map to vectors as follows. Pairs 0–3 go to vector 11. Pair p for p = 4..15 goes to vector p+8. Pair 16 goes to vector 24. A disabled pair with a set flag is never taken.
- R3: Vector 11 is pending while any of pairs 0–3 is active. It stops being pending once none of them is active.
- R4: A pending software trap (vector 27) wins over everything. An illegal opcode (vector 28) wins over everything except the software trap. Both are taken whatever the mask bits are, and accepting one clears its pending bit.
- R5: The non-maskable request (vector 26) is taken only when `x_mask` = 0, and accepting it clears it. While it is pending with `x_mask` = 1, no vector below the two traps is selected.
- R6: With `i_mask` = 1, no peripheral source and no external line source is selected.
- R7: Among the eligible peripheral and external-line sources the lowest vector index wins. These bits are not cleared on accept, so a source whose flag stays set is taken again.
- R8: `vec_addr` = base + 2 × `vec_idx`. The base is 0xFFC0 when `special_mode` = 0 and 0xBFC0 when it is 1.
- R9: With a valid vector, `set_x` = 1 and `set_i` = 0 for vector 26, and `set_i` = 1 and `set_x` = 0 otherwise. `entry_cycles` is 14.
- R10: `vec_valid` pulses for one cycle on the clock after an accept that finds an eligible source. Otherwise `vec_valid` is 0, and `vec_idx` and `vec_addr` hold their last values.
- R11: `irq_line` held at 1 makes vector 25 pending. Dropping it removes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_flag | input | 17 | Peripheral status flags, one per pair |
| periph_en | input | 17 | Enable bits matching `periph_flag` |
| irq_line | input | 1 | Level-sensitive external request (vector 25) |
| swi_req | input | 1 | Software-trap strobe |
| ill_req | input | 1 | Illegal-opcode strobe |
| xirq_req | input | 1 | Non-maskable request strobe |
| i_mask | input | 1 | Core general interrupt mask bit |
| x_mask | input | 1 | Core non-maskable mask bit |
| special_mode | input | 1 | Selects the alternate vector table base |
| accept | input | 1 | Core ready to take an interrupt |
| vec_valid | output | 1 | A vector was selected on the last accept |
| vec_idx | output | 5 | Selected vector index |
| vec_addr | output | 16 | Address of the vector table entry |
| set_i | output | 1 | Core must set its general mask |
| set_x | output | 1 | Core must set its non-maskable mask |
| entry_cycles | output | 5 | Entry overhead in cycles |

## Verification
Flags, the external line and event strobes reach the pending word on the first rising edge after they are driven. The bench drives them at a falling edge and raises `accept` only at the next falling edge. All results of an accept are registered, so they appear on the edge after `accept` is seen. The bench samples them at the falling edge that follows and then lowers `accept`. The pending state is never read directly. The bench's model of the event bits and its arbitration function predict each pick, and the hold-last-value rule is checked on the cycles with no accept.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int VEC_W     = 5;
  localparam int NUM_VEC   = 1 << VEC_W;
  localparam int NUM_PAIRS = 17;

  localparam int V_SERIAL = 11;
  localparam int V_RTI    = 24;
  localparam int V_IRQ    = 25;
  localparam int V_XIRQ   = 26;
  localparam int V_SWI    = 27;
  localparam int V_ILL    = 28;

  // vector served by each flag/enable pair
  function automatic int pair_vec(input int p);
    if (p < 4)       return V_SERIAL;
    else if (p < 16) return p + 8;
    else             return V_RTI;
  endfunction

  // vectors raised by core events and cleared on accept
  function automatic logic is_event(input int v);
    return (v == V_XIRQ) || (v == V_SWI) || (v == V_ILL);
  endfunction
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_ctrl_pkg::*;
#(
  parameter int PAIRS = NUM_PAIRS,
  parameter int NV    = NUM_VEC
) (
  input  logic [PAIRS-1:0] flag,
  input  logic [PAIRS-1:0] en,
  input  logic             irq_line,
  output logic [NV-1:0]    level_req
);
  logic [PAIRS-1:0] active;
  assign active = flag & en;

  for (genvar v = 0; v < NV; v++) begin : g_vec
    if (v == V_IRQ) begin : g_irq
      assign level_req[v] = irq_line;
    end else begin : g_pairs
      always_comb begin
        level_req[v] = 1'b0;
        for (int p = 0; p < PAIRS; p++)
          if (pair_vec(p) == v) level_req[v] = level_req[v] | active[p];
      end
    end
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_ctrl_pkg::*;
#(
  parameter int NV = NUM_VEC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NV-1:0] level_req,
  input  logic [NV-1:0] ev_set,
  input  logic [NV-1:0] ev_clr,
  output logic [NV-1:0] pend
);
  for (genvar v = 0; v < NV; v++) begin : g_bit
    if (is_event(v)) begin : g_ev
      always_ff @(posedge clk) begin
        if (rst) pend[v] <= 1'b0;
        else     pend[v] <= (pend[v] & ~ev_clr[v]) | ev_set[v];
      end
    end else begin : g_lvl
      always_ff @(posedge clk) begin
        if (rst) pend[v] <= 1'b0;
        else     pend[v] <= level_req[v];
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctrl_pkg::*;
#(
  parameter int NV = NUM_VEC,
  parameter int IW = VEC_W
) (
  input  logic [NV-1:0] pend,
  input  logic          i_mask,
  input  logic          x_mask,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic          m_hit;
  logic [IW-1:0] m_idx;

  // lowest pending maskable vector
  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int v = NV - 1; v >= 0; v--) begin
      if (pend[v] && !is_event(v)) begin
        m_hit = 1'b1;
        m_idx = IW'(v);
      end
    end
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (pend[V_SWI]) begin
      hit = 1'b1;
      idx = IW'(V_SWI);
    end else if (pend[V_ILL]) begin
      hit = 1'b1;
      idx = IW'(V_ILL);
    end else if (pend[V_XIRQ]) begin
      if (!x_mask) begin
        hit = 1'b1;
        idx = IW'(V_XIRQ);
      end
    end else if (!i_mask && m_hit) begin
      hit = 1'b1;
      idx = m_idx;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          PAIRS        = NUM_PAIRS,
  parameter int          IW           = VEC_W,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] BASE_NORMAL  = 16'hFFC0,
  parameter logic [15:0] BASE_SPECIAL = 16'hBFC0,
  parameter int          ENTRY_CYC    = 14,
  parameter int          CYC_W        = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAIRS-1:0]  periph_flag,
  input  logic [PAIRS-1:0]  periph_en,
  input  logic              irq_line,
  input  logic              swi_req,
  input  logic              ill_req,
  input  logic              xirq_req,
  input  logic              i_mask,
  input  logic              x_mask,
  input  logic              special_mode,
  input  logic              accept,
  output logic              vec_valid,
  output logic [IW-1:0]     vec_idx,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              set_i,
  output logic              set_x,
  output logic [CYC_W-1:0]  entry_cycles
);
  localparam int NV = 1 << IW;

  logic [NV-1:0] level_req, ev_set, ev_clr, pend;
  logic          hit;
  logic [IW-1:0] pick;
  logic          take;

  assign take = accept & hit;

  always_comb begin
    ev_set         = '0;
    ev_set[V_SWI]  = swi_req;
    ev_set[V_ILL]  = ill_req;
    ev_set[V_XIRQ] = xirq_req;
    ev_clr         = '0;
    if (take) ev_clr[pick] = 1'b1;
  end

  irq_src_map #(.PAIRS(PAIRS), .NV(NV)) u_map (
    .flag(periph_flag), .en(periph_en), .irq_line(irq_line), .level_req(level_req)
  );

  irq_pend_reg #(.NV(NV)) u_pend (
    .clk(clk), .rst(rst), .level_req(level_req), .ev_set(ev_set),
    .ev_clr(ev_clr), .pend(pend)
  );

  irq_pick #(.NV(NV), .IW(IW)) u_pick (
    .pend(pend), .i_mask(i_mask), .x_mask(x_mask), .hit(hit), .idx(pick)
  );

  logic [ADDR_W-1:0] base;
  assign base = special_mode ? ADDR_W'(BASE_SPECIAL) : ADDR_W'(BASE_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid    <= 1'b0;
      vec_idx      <= '0;
      vec_addr     <= '0;
      set_i        <= 1'b0;
      set_x        <= 1'b0;
      entry_cycles <= '0;
    end else begin
      vec_valid    <= take;
      set_i        <= take && (pick != IW'(V_XIRQ));
      set_x        <= take && (pick == IW'(V_XIRQ));
      entry_cycles <= take ? CYC_W'(ENTRY_CYC) : '0;
      if (take) begin
        vec_idx  <= pick;
        vec_addr <= base + (ADDR_W'(pick) << 1);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int IW     = 5,
  parameter int ADDR_W = 16,
  parameter int CYC_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic              i_mask,
  input logic              x_mask,
  input logic              special_mode,
  input logic              vec_valid,
  input logic [IW-1:0]     vec_idx,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              set_i,
  input logic              set_x,
  input logic [CYC_W-1:0]  entry_cycles
);
  assert_one_mask_R9: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $countones({set_i, set_x}) == 1);

  assert_setx_xirq_R9: assert property (@(posedge clk) disable iff (rst)
    set_x |-> (vec_valid && vec_idx == IW'(26)));

  assert_overhead_R9: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> entry_cycles == CYC_W'(14));

  assert_needs_accept_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !vec_valid);

  assert_hold_idx_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(vec_idx) && $stable(vec_addr)));

  assert_xirq_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
    accept && x_mask |=> !(vec_valid && vec_idx == IW'(26)));

  assert_imask_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    accept && i_mask |=> !(vec_valid && vec_idx < IW'(26)));

  assert_addr_base_R8: assert property (@(posedge clk) disable iff (rst)
    accept && special_mode |=> (!vec_valid || vec_addr[15:8] == 8'hBF));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.IW(IW), .ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .i_mask(i_mask), .x_mask(x_mask),
  .special_mode(special_mode), .vec_valid(vec_valid), .vec_idx(vec_idx),
  .vec_addr(vec_addr), .set_i(set_i), .set_x(set_x), .entry_cycles(entry_cycles)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] periph_flag = '0, periph_en = '0;
  logic        irq_line = 0, swi_req = 0, ill_req = 0, xirq_req = 0;
  logic        i_mask = 0, x_mask = 0, special_mode = 0, accept = 0;
  logic        vec_valid, set_i, set_x;
  logic [4:0]  vec_idx, entry_cycles;
  logic [15:0] vec_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit m_sw = 0, m_il = 0, m_xr = 0;
  int last_idx = 0;
  int last_addr = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .periph_flag(periph_flag), .periph_en(periph_en),
    .irq_line(irq_line), .swi_req(swi_req), .ill_req(ill_req), .xirq_req(xirq_req),
    .i_mask(i_mask), .x_mask(x_mask), .special_mode(special_mode), .accept(accept),
    .vec_valid(vec_valid), .vec_idx(vec_idx), .vec_addr(vec_addr),
    .set_i(set_i), .set_x(set_x), .entry_cycles(entry_cycles)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int vec_of_pair(int p);
    if (p < 4) return 11;
    if (p < 16) return p + 8;
    return 24;
  endfunction

  function automatic int model_pick(logic [16:0] f, logic [16:0] e, logic irq,
                                    logic im, logic xm);
    if (m_sw) return 27;
    if (m_il) return 28;
    if (m_xr) return xm ? -1 : 26;
    if (im) return -1;
    for (int v = 0; v < 25; v++)
      for (int p = 0; p < 17; p++)
        if (f[p] && e[p] && vec_of_pair(p) == v) return v;
    if (irq) return 25;
    return -1;
  endfunction

  function automatic string req_of(int v);
    if (v < 0) return "R10";
    if (v == 11) return "R3";
    if (v == 25) return "R11";
    if (v == 26) return "R5";
    if (v >= 27) return "R4";
    return "R7";
  endfunction

  task automatic txn(logic [16:0] f, logic [16:0] e, logic irq, logic sw, logic il,
                     logic xr, logic im, logic xm, logic sp, logic acc, string tag);
    int exp;
    @(negedge clk);
    periph_flag = f; periph_en = e; irq_line = irq;
    swi_req = sw; ill_req = il; xirq_req = xr;
    i_mask = im; x_mask = xm; special_mode = sp;
    if (sw) m_sw = 1;
    if (il) m_il = 1;
    if (xr) m_xr = 1;
    @(negedge clk);
    swi_req = 0; ill_req = 0; xirq_req = 0;
    accept = acc;
    exp = acc ? model_pick(f, e, irq, im, xm) : -1;
    @(negedge clk);
    accept = 0;
    if (exp == 27) m_sw = 0;
    if (exp == 28) m_il = 0;
    if (exp == 26) m_xr = 0;
    if (exp >= 0) begin
      last_idx = exp;
      last_addr = (sp ? 16'hBFC0 : 16'hFFC0) + 2 * exp;
    end
    check(tag.len() > 0 ? tag : req_of(exp), int'(vec_valid), int'(exp >= 0), "valid");
    check(tag.len() > 0 ? tag : req_of(exp), int'(vec_idx), last_idx, "idx");
    check("R8", int'(vec_addr), last_addr, "addr");
    if (exp >= 0) begin
      check("R9", int'(set_x), int'(exp == 26), "set_x");
      check("R9", int'(set_i), int'(exp != 26), "set_i");
      check("R9", int'(entry_cycles), 14, "entry_cycles");
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(vec_valid), 0, "valid");
    check("R1", int'(vec_idx), 0, "idx");
    check("R1", int'(vec_addr), 0, "addr");
    check("R1", int'(entry_cycles), 0, "cycles");
    txn('0, '0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    // R2 disabled pair ignored, enabled pair taken
    txn(17'h00010, 17'h0, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    txn(17'h00010, 17'h00010, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    txn(17'h10000, 17'h10000, 0, 0, 0, 0, 0, 0, 1, 1, "R2");
    // R3 every serial pair shares vector 11
    for (int p = 0; p < 4; p++)
      txn(17'(1 << p) | 17'h00100, 17'h1FFFF, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
    txn(17'h00100, 17'h1FFFF, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
    // R4 traps ignore both masks, swi before illegal
    txn(17'h1FFFF, 17'h1FFFF, 1, 1, 1, 1, 1, 1, 0, 1, "R4");
    txn(17'h1FFFF, 17'h1FFFF, 1, 0, 0, 0, 1, 1, 0, 1, "R4");
    // R5 xirq masked blocks everything, then taken when unmasked
    txn(17'h1FFFF, 17'h1FFFF, 1, 0, 0, 0, 0, 1, 0, 1, "R5");
    txn(17'h1FFFF, 17'h1FFFF, 1, 0, 0, 0, 1, 0, 1, 1, "R5");
    // R6 general mask
    txn(17'h1FFFF, 17'h1FFFF, 1, 0, 0, 0, 1, 0, 0, 1, "R6");
    // R7 stays pending and taken again
    txn(17'h00300, 17'h1FFFF, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
    txn(17'h00300, 17'h1FFFF, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R11 external line
    txn('0, '0, 1, 0, 0, 0, 0, 0, 0, 1, "R11");
    txn('0, '0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");
    // R10 no accept holds outputs
    txn(17'h1FFFF, 17'h1FFFF, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
    for (int n = 0; n < 400; n++) begin
      logic [16:0] f, e;
      f = 17'($urandom) & 17'($urandom);
      e = 17'($urandom);
      txn(f, e, ($urandom % 4) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
          ($urandom % 12) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
          1'($urandom), ($urandom % 8) != 0, "");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule